// File: doc/BRIEF.md
# Voice Converter Serial Port Controller

This block sits between a chip's digital voice path and an external 14-bit voice A/D and D/A converter. The converter owns the serial timing. It produces the shift clock and an 8 kHz frame sync. The block samples those lines in its own clock domain through a synchronizer.

In every frame the block receives one 16-bit word and transmits one 16-bit word. The received word carries a 14-bit conversion result in its upper bits. The block sign-extends that result and presents it with a one-cycle strobe. The transmitted word carries a 14-bit output sample in its upper bits and a 2-bit control field in its lowest bits.

Software-free reconfiguration of the converter runs in-band. A configuration request marks the next frame's control field as "control word follows". The frame after that carries the raw 16-bit configuration word in place of a sample. If the upstream path fails to supply a new output sample before a frame begins, the previous sample is sent again and an underrun pulse is raised.

Top module: `vcodec_sport`

## Requirements
- R1: During and directly after reset, `cnv_dout`, `smp_out_vld`, `underrun` and `cfg_busy` are 0, and `smp_out` is 0.
- R2: A received frame starts at the shift-clock falling edge on which frame sync is high. Sixteen bits are taken MSB first on that edge and the next fifteen falling edges. `smp_out` becomes bits 15:2 sign-extended to 16 bits, and the received bits 1:0 have no effect on it.
- R3: Each complete received frame gives exactly one `smp_out_vld` pulse of one clock. `smp_out` changes only together with that pulse.
- R4: A transmitted word is driven MSB first. Bit 15 appears on `cnv_dout` once the rising frame sync is seen, and each following shift-clock rising edge advances one bit. A normal frame's word is {sample[13:0], 2'b00}.
- R5: A sample offered with `smp_in_vld` before a frame sync is sent in that frame. It is consumed exactly once.
- R6: If no new sample was offered since the last sample frame, the last sample is sent again. `underrun` then pulses for one clock at that frame's start.
- R7: After an accepted configuration request, the next frame's word is {sample, 2'b11}. The frame after that carries `cfg_word` verbatim.
- R8: `cfg_busy` rises only in the cycle after a `cfg_req` and falls when the control frame starts. A `cfg_req` while busy is ignored.
- R9: A control-word frame consumes no sample and raises no `underrun`.
- R10: Outside the 16 bit periods of a frame, `cnv_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_sclk | input | 1 | Shift clock from the converter |
| cnv_fs | input | 1 | Frame sync from the converter, 8 kHz |
| cnv_din | input | 1 | Serial data from the converter (A/D result) |
| cnv_dout | output | 1 | Serial data to the converter (D/A sample or control) |
| smp_in | input | 14 | Output sample to be converted |
| smp_in_vld | input | 1 | Strobe offering `smp_in` |
| smp_out | output | 16 | Received sample, sign-extended |
| smp_out_vld | output | 1 | One-cycle strobe for `smp_out` |
| underrun | output | 1 | Pulse: a sample was repeated |
| cfg_req | input | 1 | Request to send `cfg_word` to the converter |
| cfg_word | input | 16 | Converter programming word |
| cfg_busy | output | 1 | A configuration sequence is pending |

## Verification
The hardest situation to reach is the overlap of the configuration sequence with sample supply. That covers a second request arriving while the first is pending, and a fresh sample offered just before the control frame that must survive it unconsumed. Directed frames set up both cases in sequence: a request, a second ignored request, and a sample before the control frame. Seeded random frames then mix missing samples, requests and arbitrary received words, including words whose low bits are set and whose sign bit is set.

// File: rtl/vcsp_pkg.sv
package vcsp_pkg;

    localparam int WORD_W   = 16;
    localparam int SAMPLE_W = 14;
    localparam int CTRL_W   = WORD_W - SAMPLE_W;
    localparam int CNT_W    = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [SAMPLE_W-1:0] smp_t;

    typedef enum logic [CTRL_W-1:0] {
        CB_SAMPLE    = 2'b00,
        CB_NEXT_CTRL = 2'b11
    } ctrl_bits_e;

    typedef enum logic [1:0] {
        CFG_IDLE,
        CFG_FLAG,
        CFG_SEND
    } cfg_state_e;

    typedef struct packed {
        word_t word;
        logic  consume;
        logic  repeat_smp;
    } tx_choice_t;

    function automatic word_t sign_ext(input word_t w);
        return {{CTRL_W{w[WORD_W-1]}}, w[WORD_W-1:CTRL_W]};
    endfunction

    function automatic word_t pack_sample(input smp_t s, input ctrl_bits_e c);
        return {s, c};
    endfunction

endpackage

// File: rtl/vcsp_sync.sv
module vcsp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/vcsp_rx.sv
module vcsp_rx
    import vcsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_fall,
    input  logic  fs,
    input  logic  din,
    output word_t smp_out,
    output logic  smp_vld
);
    word_t            sh;
    logic [CNT_W-1:0] cnt;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            active  <= 1'b0;
            smp_out <= '0;
            smp_vld <= 1'b0;
        end else begin
            smp_vld <= 1'b0;
            if (active && cnt == CNT_W'(WORD_W)) begin
                smp_out <= sign_ext(sh);
                smp_vld <= 1'b1;
                active  <= 1'b0;
            end else if (sclk_fall) begin
                if (fs) begin
                    sh     <= {{(WORD_W-1){1'b0}}, din};
                    cnt    <= CNT_W'(1);
                    active <= 1'b1;
                end else if (active) begin
                    sh  <= {sh[WORD_W-2:0], din};
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vcsp_tx.sv
module vcsp_tx
    import vcsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t word,
    input  logic  sclk_rise,
    output logic  dout
);
    word_t            sh;
    logic [CNT_W-1:0] left;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            left   <= '0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= word;
            left   <= CNT_W'(WORD_W - 1);
            active <= 1'b1;
        end else if (sclk_rise && active) begin
            if (left == '0) begin
                active <= 1'b0;
                sh     <= '0;
            end else begin
                sh   <= {sh[WORD_W-2:0], 1'b0};
                left <= left - CNT_W'(1);
            end
        end
    end

    assign dout = active & sh[WORD_W-1];
endmodule

// File: rtl/vcsp_frame_sel.sv
module vcsp_frame_sel
    import vcsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  smp_t  smp_in,
    input  logic  smp_in_vld,
    input  logic  cfg_req,
    input  word_t cfg_word,
    output word_t word,
    output logic  cfg_busy,
    output logic  underrun
);
    smp_t       staged;
    logic       fresh;
    cfg_state_e cfg_st;
    word_t      cfg_reg;
    tx_choice_t pick;

    always_comb begin
        pick = '0;
        unique case (cfg_st)
            CFG_SEND: begin
                pick.word = cfg_reg;
            end
            CFG_FLAG: begin
                pick.word       = pack_sample(staged, CB_NEXT_CTRL);
                pick.consume    = 1'b1;
                pick.repeat_smp = ~fresh;
            end
            default: begin
                pick.word       = pack_sample(staged, CB_SAMPLE);
                pick.consume    = 1'b1;
                pick.repeat_smp = ~fresh;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged   <= '0;
            fresh    <= 1'b0;
            cfg_st   <= CFG_IDLE;
            cfg_reg  <= '0;
            underrun <= 1'b0;
        end else begin
            underrun <= load & pick.repeat_smp;
            if (load && pick.consume) begin
                fresh <= 1'b0;
            end
            if (smp_in_vld) begin
                staged <= smp_in;
                fresh  <= 1'b1;
            end
            if (load) begin
                unique case (cfg_st)
                    CFG_FLAG: cfg_st <= CFG_SEND;
                    CFG_SEND: cfg_st <= CFG_IDLE;
                    default:  cfg_st <= CFG_IDLE;
                endcase
            end
            if (cfg_req && cfg_st == CFG_IDLE) begin
                cfg_st  <= CFG_FLAG;
                cfg_reg <= cfg_word;
            end
        end
    end

    assign word     = pick.word;
    assign cfg_busy = (cfg_st != CFG_IDLE);
endmodule

// File: rtl/vcodec_sport.sv
module vcodec_sport
    import vcsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnv_sclk,
    input  logic                cnv_fs,
    input  logic                cnv_din,
    output logic                cnv_dout,
    input  logic [SAMPLE_W-1:0] smp_in,
    input  logic                smp_in_vld,
    output logic [WORD_W-1:0]   smp_out,
    output logic                smp_out_vld,
    output logic                underrun,
    input  logic                cfg_req,
    input  logic [WORD_W-1:0]   cfg_word,
    output logic                cfg_busy
);
    logic [2:0] raw_lines;
    logic [2:0] sync_lines;
    logic       sclk_s, fs_s, din_s;
    logic       sclk_q, fs_q;
    logic       sclk_rise, sclk_fall, fs_rise;
    word_t      tx_word;

    assign raw_lines = {cnv_sclk, cnv_fs, cnv_din};

    vcsp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    assign {sclk_s, fs_s, din_s} = sync_lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            fs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            fs_q   <= fs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign fs_rise   = fs_s & ~fs_q;

    vcsp_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sclk_fall (sclk_fall),
        .fs        (fs_s),
        .din       (din_s),
        .smp_out   (smp_out),
        .smp_vld   (smp_out_vld)
    );

    vcsp_frame_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .load       (fs_rise),
        .smp_in     (smp_in),
        .smp_in_vld (smp_in_vld),
        .cfg_req    (cfg_req),
        .cfg_word   (cfg_word),
        .word       (tx_word),
        .cfg_busy   (cfg_busy),
        .underrun   (underrun)
    );

    vcsp_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (fs_rise),
        .word      (tx_word),
        .sclk_rise (sclk_rise),
        .dout      (cnv_dout)
    );
endmodule

// File: rtl/vcsp_chk.sv
module vcsp_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] smp_out,
    input logic        smp_out_vld,
    input logic        underrun,
    input logic        cfg_req,
    input logic        cfg_busy
);
    p_vld_single_r3: assert property (@(posedge clk) disable iff (rst)
        smp_out_vld |=> !smp_out_vld);

    p_out_only_on_vld_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(smp_out) |-> smp_out_vld);

    p_sign_ext_r2: assert property (@(posedge clk) disable iff (rst)
        smp_out_vld |-> (smp_out[15:13] == 3'b000 || smp_out[15:13] == 3'b111));

    p_underrun_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun);

    p_busy_from_req_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_busy) |-> $past(cfg_req));
endmodule

bind vcodec_sport vcsp_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_out     (smp_out),
    .smp_out_vld (smp_out_vld),
    .underrun    (underrun),
    .cfg_req     (cfg_req),
    .cfg_busy    (cfg_busy)
);

// File: tb/sim_vcodec_sport.sv
module sim_vcodec_sport;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnv_sclk = 1'b0;
    logic        cnv_fs = 1'b0;
    logic        cnv_din = 1'b0;
    logic        cnv_dout;
    logic [13:0] smp_in = '0;
    logic        smp_in_vld = 1'b0;
    logic [15:0] smp_out;
    logic        smp_out_vld;
    logic        underrun;
    logic        cfg_req = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        cfg_busy;

    int errors = 0;
    int checks = 0;
    int vld_cnt = 0;
    int und_cnt = 0;
    logic [15:0] last_rx = '0;
    bit done = 0;

    logic [13:0] m_staged = '0;
    bit          m_fresh = 0;
    int          m_st = 0;
    logic [15:0] m_cfg = '0;

    always #4 clk = ~clk;

    vcodec_sport u0 (
        .clk(clk), .rst(rst), .cnv_sclk(cnv_sclk), .cnv_fs(cnv_fs),
        .cnv_din(cnv_din), .cnv_dout(cnv_dout), .smp_in(smp_in),
        .smp_in_vld(smp_in_vld), .smp_out(smp_out), .smp_out_vld(smp_out_vld),
        .underrun(underrun), .cfg_req(cfg_req), .cfg_word(cfg_word),
        .cfg_busy(cfg_busy)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (smp_out_vld) begin
                vld_cnt++;
                last_rx = smp_out;
            end
            if (underrun) und_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rx(input logic [15:0] w);
        return {{2{w[15]}}, w[15:2]};
    endfunction

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic give_sample(input logic [13:0] s);
        @(negedge clk);
        smp_in = s; smp_in_vld = 1'b1;
        @(negedge clk);
        smp_in_vld = 1'b0;
        m_staged = s; m_fresh = 1;
    endtask

    task automatic give_cfg(input logic [15:0] w);
        @(negedge clk);
        cfg_word = w; cfg_req = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0;
        if (m_st == 0) begin m_st = 1; m_cfg = w; end
    endtask

    task automatic predict(output logic [15:0] w, output int und);
        und = 0;
        if (m_st == 2) begin
            w = m_cfg; m_st = 0;
        end else begin
            w = {m_staged, (m_st == 1) ? 2'b11 : 2'b00};
            und = m_fresh ? 0 : 1;
            m_fresh = 0;
            if (m_st == 1) m_st = 2;
        end
    endtask

    task automatic frame(input logic [15:0] rxw);
        logic [15:0] txw;
        logic [15:0] ew;
        int eu, v0, u0c;
        bit idle_bad;
        predict(ew, eu);
        v0 = vld_cnt; u0c = und_cnt; idle_bad = 0;
        for (int i = 0; i < 16; i++) begin
            cnv_sclk = 1'b1; cnv_din = rxw[15-i]; cnv_fs = (i == 0);
            half();
            txw[15-i] = cnv_dout;
            cnv_sclk = 1'b0;
            half();
        end
        for (int i = 0; i < 3; i++) begin
            cnv_sclk = 1'b1; cnv_fs = 1'b0; cnv_din = 1'($urandom);
            half();
            if (cnv_dout !== 1'b0) idle_bad = 1;
            cnv_sclk = 1'b0;
            half();
        end
        chk(txw == ew, "R4/R7", "tx word", txw, ew);
        chk(last_rx == exp_rx(rxw), "R2", "rx sample", last_rx, exp_rx(rxw));
        chk(vld_cnt - v0 == 1, "R3", "valid pulses", vld_cnt - v0, 1);
        chk(und_cnt - u0c == eu, "R6", "underrun pulses", und_cnt - u0c, eu);
        chk(!idle_bad, "R10", "idle dout", idle_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cnv_dout == 0 && smp_out_vld == 0 && underrun == 0 && cfg_busy == 0,
            "R1", "outputs in reset", {cnv_dout, smp_out_vld, underrun, cfg_busy}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(smp_out == 0 && cnv_dout == 0 && cfg_busy == 0, "R1", "after reset",
            smp_out, 0);

        // R6: no sample ever offered, zero repeated
        frame(16'h1234);
        // R5: fresh sample sent, R2 negative word with low bits set
        give_sample(14'h1FFF);
        frame(16'h8003);
        // R6: repeat of 1FFF
        frame(16'h7FFC);
        // R7/R8 configuration sequence
        give_sample(14'h2000);
        give_cfg(16'hA5C3);
        chk(cfg_busy == 1, "R8", "busy after request", cfg_busy, 1);
        give_cfg(16'h1234);
        frame(16'h0001);
        chk(cfg_busy == 1, "R8", "busy through flag frame", cfg_busy, 1);
        // R9: sample offered before control frame must survive it
        give_sample(14'h0ABC);
        frame(16'hFFFF);
        chk(cfg_busy == 0, "R8", "busy cleared after control frame", cfg_busy, 0);
        frame(16'h4000);

        for (int n = 0; n < 40; n++) begin
            if ($urandom % 4 != 0) give_sample(14'($urandom));
            if ($urandom % 8 == 0) give_cfg(16'($urandom));
            chk(cfg_busy == (m_st != 0), "R8", "busy tracks pending", cfg_busy, m_st != 0);
            frame(16'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule